// File: doc/BRIEF.md
# I2C Register-Write Target

This block is an I2C target that lets a bus master configure a small bank of byte-wide registers. A frame opens with START and a 7-bit device address plus a direction bit. In a write frame the master then sends a register pointer byte and a data byte. That pair may be repeated as often as wanted before STOP, and each pair writes exactly one register. The pointer never advances by itself. A read frame returns the register named by the most recent pointer, once for every byte the master asks for.

SCL and SDA reach the block as plain inputs. The block pulls SDA low through a single drive-low enable, and the board supplies the pull-up. Two strap pins set the low bits of the device address. Every register is visible in parallel on a flat output bus. Each register update is also announced by a one-cycle strobe carrying the index and the data, so that neighbouring logic can react to configuration changes.

Top module: `i2c_regwr_target`

## Requirements
- R1: The target pulls SDA low during the ninth SCL pulse after every address, pointer and data byte that it accepts in a write frame.
- R2: The target answers to the 7-bit address {DEV_HI (5 bits, default 5'b10010), strap[1], strap[0]}, sent MSB first in bits [7:1] of the first byte, with bit 0 as R/W (0 = write, 1 = read). On a mismatch it gives no ACK and ignores the rest of the frame up to the next START.
- R3: In a pointer byte, bits [7:1] are the register index and bit 0 has no effect.
- R4: A data byte writes the register selected by the preceding pointer. At the SCL fall that starts the data byte's ACK, wr_stb pulses high for exactly one clock with wr_idx and wr_data, and regs_flat[8*i +: 8] then shows the new value.
- R5: Repeated pointer/data pairs within one frame each write their own register, with no auto-increment.
- R6: A pointer index of 12 (0x0C) or higher (NUM_REGS and up) is reserved. Data written there is still ACKed, but it causes no strobe and changes no register.
- R7: A START or repeated START always returns the target to expecting an address byte. A STOP or START that comes after a pointer byte but before its data byte writes nothing.
- R8: In a read frame, the target shifts out the register at the current pointer, MSB first. Each master ACK repeats the same register, and a reserved pointer reads as 0x00.
- R9: After a master NACK the target keeps SDA released until the next START or STOP, whatever SCL does.
- R10: The drive-low enable changes only after an SCL falling edge, or on a START or STOP. It never changes while SCL is high within a byte.
- R11: After reset every register reads 0x00, and sda_oe and wr_stb are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which must be much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Level of the SCL bus line |
| sda_i | input | 1 | Level of the SDA bus line |
| strap | input | STRAP_W | Address strap pins, the low bits of the device address |
| sda_oe | output | 1 | When high, SDA is pulled low |
| wr_stb | output | 1 | One-cycle pulse for each register update |
| wr_idx | output | 7 | Register index that goes with wr_stb |
| wr_data | output | 8 | Data that goes with wr_stb |
| regs_flat | output | 8*NUM_REGS | All registers; register i is at [8*i +: 8] |

## Verification
The bench builds the block with its default values: twelve registers, a two-bit strap, the upper address bits 5'b10010 and two synchroniser stages. With twelve registers, index 0x0B is the last valid one and 0x0C is the first reserved one, so the boundary of R6 lies inside the 7-bit pointer range. It is tested from both sides, together with a far index of 0x7F. Because the strap is two bits wide, changing the strap pins mid-run shows whether the same address byte is accepted or refused.

// File: rtl/i2c_rw_pkg.sv
package i2c_rw_pkg;
  localparam int ADDR_W = 7;
  localparam int IDX_W  = 7;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_DECIDE,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_IGNORE
  } eng_state_t;

  typedef enum logic [1:0] {
    PH_DEV,
    PH_PTR,
    PH_DATA
  } byte_phase_t;

  // register index carried by a pointer byte (bit 0 is a don't-care)
  function automatic logic [IDX_W-1:0] ptr_index(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1:1];
  endfunction

  // does the first byte of a frame select this target
  function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                    input logic [ADDR_W-1:0] own);
    return b[BYTE_W-1:1] == own;
  endfunction

  // is an index backed by a real register
  function automatic logic idx_ok(input logic [IDX_W-1:0] idx, input int n);
    return int'({25'd0, idx}) < n;
  endfunction

  // byte kind expected after an acknowledged write-mode byte
  function automatic byte_phase_t next_phase(input byte_phase_t p);
    return (p == PH_PTR) ? PH_DATA : PH_PTR;
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;

  // R7
  bus_event_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_evt, stop_evt, scl_rise, scl_fall}));
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_rw_pkg::*;
#(
  parameter int NUM_REGS = 12,
  parameter int STRAP_W  = 2,
  parameter logic [ADDR_W-STRAP_W-1:0] DEV_HI = 5'b10010
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_evt,
  input  logic               stop_evt,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               sda_s,
  input  logic [STRAP_W-1:0] strap,
  input  logic [BYTE_W-1:0]  rd_data,
  output logic [IDX_W-1:0]   ptr,
  output logic               sda_oe,
  output logic               wr_stb,
  output logic [IDX_W-1:0]   wr_idx,
  output logic [BYTE_W-1:0]  wr_data
);
  eng_state_t        st;
  byte_phase_t       ph;
  logic [BYTE_W-1:0] sh;
  logic [2:0]        bcnt;
  logic              rd_mode;
  logic              mack_ok;
  logic [ADDR_W-1:0] own_addr;
  logic [BYTE_W-1:0] rx_next;
  logic              byte_last;

  assign own_addr  = {DEV_HI, strap};
  assign rx_next   = {sh[BYTE_W-2:0], sda_s};
  assign byte_last = (bcnt == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ph      <= PH_DEV;
      sh      <= '0;
      bcnt    <= '0;
      rd_mode <= 1'b0;
      mack_ok <= 1'b0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_evt) begin
        st      <= ST_RX;
        ph      <= PH_DEV;
        bcnt    <= '0;
        rd_mode <= 1'b0;
        sda_oe  <= 1'b0;
      end else if (stop_evt) begin
        st     <= ST_IDLE;
        ph     <= PH_DEV;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_RX: if (scl_rise) begin
            sh   <= rx_next;
            bcnt <= bcnt + 3'd1;
            if (byte_last) st <= ST_DECIDE;
          end
          ST_DECIDE: if (scl_fall) begin
            case (ph)
              PH_DEV: begin
                if (addr_hit(sh, own_addr)) begin
                  rd_mode <= sh[0];
                  sda_oe  <= 1'b1;
                  st      <= ST_ACK;
                end else begin
                  st <= ST_IGNORE;
                end
              end
              PH_PTR: begin
                ptr    <= ptr_index(sh);
                sda_oe <= 1'b1;
                st     <= ST_ACK;
              end
              default: begin
                if (idx_ok(ptr, NUM_REGS)) begin
                  wr_stb  <= 1'b1;
                  wr_idx  <= ptr;
                  wr_data <= sh;
                end
                sda_oe <= 1'b1;
                st     <= ST_ACK;
              end
            endcase
          end
          ST_ACK: if (scl_fall) begin
            bcnt <= '0;
            if (ph == PH_DEV && rd_mode) begin
              st     <= ST_TX;
              sh     <= rd_data;
              sda_oe <= ~rd_data[BYTE_W-1];
            end else begin
              st     <= ST_RX;
              ph     <= next_phase(ph);
              sda_oe <= 1'b0;
            end
          end
          ST_TX: if (scl_fall) begin
            if (byte_last) begin
              sda_oe  <= 1'b0;
              mack_ok <= 1'b0;
              st      <= ST_MACK;
            end else begin
              sh     <= {sh[BYTE_W-2:0], 1'b0};
              sda_oe <= ~sh[BYTE_W-2];
              bcnt   <= bcnt + 3'd1;
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              if (sda_s) st <= ST_IGNORE;
              else mack_ok <= 1'b1;
            end else if (scl_fall && mack_ok) begin
              st      <= ST_TX;
              sh      <= rd_data;
              sda_oe  <= ~rd_data[BYTE_W-1];
              bcnt    <= '0;
              mack_ok <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10
  oe_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) || ($fell(sda_oe) && !$past(start_evt) && !$past(stop_evt)))
      |-> $past(scl_fall));

  // R4
  stb_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R7
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (!sda_oe && !wr_stb));

  // R9
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IGNORE) |-> !sda_oe);
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
  import i2c_rw_pkg::*;
#(
  parameter int NUM_REGS = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_stb,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [BYTE_W-1:0]          wr_data,
  input  logic [IDX_W-1:0]           rd_idx,
  output logic [BYTE_W-1:0]          rd_data,
  output logic [BYTE_W*NUM_REGS-1:0] regs_flat
);
  logic [BYTE_W-1:0] bank [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bank[g] <= '0;
      else if (wr_stb && wr_idx == IDX_W'(g)) bank[g] <= wr_data;
    end
    assign regs_flat[g*BYTE_W +: BYTE_W] = bank[g];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_idx == IDX_W'(i)) rd_data = bank[i];
    end
  end

  // R6
  reserved_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !idx_ok(wr_idx, NUM_REGS)) |=> $stable(regs_flat));
endmodule

// File: rtl/i2c_regwr_target.sv
module i2c_regwr_target
  import i2c_rw_pkg::*;
#(
  parameter int NUM_REGS    = 12,
  parameter int STRAP_W     = 2,
  parameter logic [ADDR_W-STRAP_W-1:0] DEV_HI = 5'b10010,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_i,
  input  logic                       sda_i,
  input  logic [STRAP_W-1:0]         strap,
  output logic                       sda_oe,
  output logic                       wr_stb,
  output logic [IDX_W-1:0]           wr_idx,
  output logic [BYTE_W-1:0]          wr_data,
  output logic [BYTE_W*NUM_REGS-1:0] regs_flat
);
  logic              sda_s, start_evt, stop_evt, scl_rise, scl_fall;
  logic [IDX_W-1:0]  ptr;
  logic [BYTE_W-1:0] rd_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  i2c_byte_engine #(.NUM_REGS(NUM_REGS), .STRAP_W(STRAP_W), .DEV_HI(DEV_HI)) u_eng (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s), .strap(strap),
    .rd_data(rd_data), .ptr(ptr), .sda_oe(sda_oe), .wr_stb(wr_stb),
    .wr_idx(wr_idx), .wr_data(wr_data)
  );

  i2c_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(ptr), .rd_data(rd_data), .regs_flat(regs_flat)
  );

  // R6
  stb_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> idx_ok(wr_idx, NUM_REGS));
endmodule

// File: tb/i2c_regwr_target_bench.sv
`timescale 1ns/1ps
module i2c_regwr_target_bench;
  localparam int NR = 12;
  localparam int H  = 8;
  localparam logic [4:0] HI = 5'b10010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [1:0] strap = 2'b10;
  logic sda_oe, wr_stb;
  logic [6:0] wr_idx;
  logic [7:0] wr_data;
  logic [8*NR-1:0] regs_flat;
  wire sda_line = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_regwr_target u_i2c_regwr_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .strap(strap),
    .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data),
    .regs_flat(regs_flat)
  );

  int n_chk = 0;
  int n_fail = 0;
  int r10_viol = 0;
  logic [7:0] model [NR];
  logic [14:0] exp_q [$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every strobe must match the next expected write
  always @(negedge clk) begin
    if (rst_n && wr_stb) begin
      if (exp_q.size() == 0) begin
        check("R6 unexpected strobe idx", {25'd0, wr_idx}, 32'hFFFF);
      end else begin
        logic [14:0] e;
        e = exp_q.pop_front();
        check("R4 strobe idx/data", {17'd0, wr_idx, wr_data}, {17'd0, e});
      end
    end
  end

  // R10 monitor: drive-low enable must not move while SCL was high
  logic scl_pos = 1'b1;
  logic oe_prev = 1'b0;
  always @(posedge clk) scl_pos <= scl_m;
  always @(negedge clk) begin
    if (rst_n && sda_oe != oe_prev && scl_pos) r10_viol++;
    oe_prev <= sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(H/2);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H);
    scl_m = 1'b0; tick(H/2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(H/2);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic put_bit(input logic b, output logic seen);
    sda_m = b; tick(H/2);
    scl_m = 1'b1; tick(H);
    seen = sda_line;
    scl_m = 1'b0; tick(H/2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) put_bit(b[i], s);
    put_bit(1'b1, s);
    acked = !s;
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      put_bit(1'b1, s);
      b[i] = s;
    end
    put_bit(!give_ack, s);
  endtask

  function automatic logic [7:0] dev(input logic [1:0] st, input logic rw);
    return {HI, st, rw};
  endfunction

  task automatic expect_write(input logic [7:0] pbyte, input logic [7:0] d);
    if (int'(pbyte[7:1]) < NR) begin
      exp_q.push_back({pbyte[7:1], d});
      model[pbyte[7:1]] = d;
    end
  endtask

  task automatic pair(input logic [7:0] pbyte, input logic [7:0] d, input string req);
    logic a;
    send_byte(pbyte, a);
    check({req, " R1 pointer ack"}, a, 1'b1);
    expect_write(pbyte, d);
    send_byte(d, a);
    check({req, " R1 data ack"}, a, 1'b1);
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < NR; i++) check(req, regs_flat[i*8 +: 8], model[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] rb;
    for (int i = 0; i < NR; i++) model[i] = 8'h00;
    tick(4);
    // R11 reset state
    check("R11 sda_oe", sda_oe, 1'b0);
    check("R11 wr_stb", wr_stb, 1'b0);
    check("R11 regs", regs_flat, '0);
    rst_n = 1'b1;
    tick(10);

    // R1 R2 R4 single write
    bus_start();
    send_byte(dev(2'b10, 1'b0), a);
    check("R2 address ack", a, 1'b1);
    pair(8'h06, 8'hA5, "R4");
    bus_stop();
    tick(4);
    check("R4 reg3", regs_flat[3*8 +: 8], 8'hA5);

    // R3 pointer bit 0 is ignored
    bus_start();
    send_byte(dev(2'b10, 1'b0), a);
    pair(8'h0B, 8'h3C, "R3");
    bus_stop();
    tick(4);
    check("R3 reg5 via odd pointer", regs_flat[5*8 +: 8], 8'h3C);

    // R5 several pairs in one frame, including last valid index 0x0B
    bus_start();
    send_byte(dev(2'b10, 1'b0), a);
    pair(8'h00, 8'h11, "R5");
    pair(8'h16, 8'h22, "R5");
    pair(8'h0E, 8'h33, "R5");
    bus_stop();
    tick(4);
    check_regs("R5 regs after pairs");

    // R6 reserved indices 0x0C and 0x7F
    bus_start();
    send_byte(dev(2'b10, 1'b0), a);
    pair(8'h18, 8'hFF, "R6");
    pair(8'hFE, 8'hEE, "R6");
    bus_stop();
    tick(4);
    check_regs("R6 regs unchanged");

    // R2 mismatch: wrong strap bits, no ack, nothing written
    bus_start();
    send_byte(dev(2'b01, 1'b0), a);
    check("R2 mismatch no ack", a, 1'b0);
    send_byte(8'h02, a);
    check("R2 ignored pointer no ack", a, 1'b0);
    send_byte(8'h99, a);
    check("R2 ignored data no ack", a, 1'b0);
    bus_stop();
    tick(4);
    check_regs("R2 regs after mismatch");

    // R2 strap pins move the address
    strap = 2'b01;
    tick(4);
    bus_start();
    send_byte(dev(2'b01, 1'b0), a);
    check("R2 new strap ack", a, 1'b1);
    pair(8'h12, 8'h6B, "R2");
    bus_stop();
    strap = 2'b10;
    tick(4);
    check("R2 reg9", regs_flat[9*8 +: 8], 8'h6B);

    // R7 STOP after pointer writes nothing; next frame starts with pointer
    bus_start();
    send_byte(dev(2'b10, 1'b0), a);
    send_byte(8'h04, a);
    bus_stop();
    tick(4);
    check_regs("R7 stop mid-pair");
    bus_start();
    send_byte(dev(2'b10, 1'b0), a);
    pair(8'h08, 8'h5A, "R7");
    bus_stop();
    tick(4);
    check("R7 reg4", regs_flat[4*8 +: 8], 8'h5A);

    // R7 repeated START mid-pair returns to address phase
    bus_start();
    send_byte(dev(2'b10, 1'b0), a);
    send_byte(8'h02, a);
    bus_start();
    send_byte(dev(2'b10, 1'b0), a);
    check("R7 address after repeated start", a, 1'b1);
    pair(8'h10, 8'h77, "R7");
    bus_stop();
    tick(4);
    check_regs("R7 regs after repeated start");

    // R8 R9 read of current pointer, no auto-increment, NACK release
    bus_start();
    send_byte(dev(2'b10, 1'b0), a);
    send_byte(8'h06, a);
    bus_start();
    send_byte(dev(2'b10, 1'b1), a);
    check("R8 read address ack", a, 1'b1);
    read_byte(1'b1, rb);
    check("R8 first read", rb, 8'hA5);
    read_byte(1'b0, rb);
    check("R8 repeat read same reg", rb, 8'hA5);
    begin
      int low_seen = 0;
      for (int i = 0; i < 9; i++) begin
        put_bit(1'b1, a);
        if (!a) low_seen++;
      end
      check("R9 released after NACK", low_seen, 0);
    end
    bus_stop();

    // R8 reserved pointer reads zero
    bus_start();
    send_byte(dev(2'b10, 1'b0), a);
    send_byte(8'h18, a);
    bus_start();
    send_byte(dev(2'b10, 1'b1), a);
    read_byte(1'b0, rb);
    check("R8 reserved read", rb, 8'h00);
    bus_stop();
    tick(10);

    check("R4 all expected strobes seen", exp_q.size(), 0);
    check("R10 no oe change while SCL high", r10_viol, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule